// File: doc/BRIEF.md
# Memory Overlay Address Controller

This block sits between a DSP core and its memories and decides, for each access, where a 14-bit word address goes: on-chip RAM, a 32-entry window of memory-mapped registers, or an external bus. The core has two ports. One is an instruction fetch port, which always addresses program space. The other is a data access port, which can address either program space (24-bit words) or data space (16-bit words). Two overlay registers choose what fills one 8K half of each space. The program register selects the upper half of program space. The data register selects the lower half of data space. An overlay value of 0 keeps that half on chip. A value of 1 or 2 sends the half to external page 1 or 2. The page number is carried on external address bit 13.

A static mode strap selects a compatibility layout. In that layout the lower half of program space is external and the upper half is internal. The program overlay register is then held at 0. Data space behaves the same in both layouts.

External accesses run one at a time, with a fixed number of wait states. The core's ready signal stays low until every access the core has requested in the current cycle is complete. When a fetch and a data access both need the bus, the data access is served first.

Top module: `ovl_addr_ctrl`

## Requirements
- R1: Program space routing in normal mode (strap 0). Addresses 0x0000–0x1FFF go to internal RAM. Addresses 0x2000–0x3FFF also go to internal RAM while the program overlay is 0. This holds for both the fetch port (`ram_fetch_en`) and a program-space data access (`ram_pmdata_en`).
- R2: Program space overlay. In normal mode, with the program overlay at 1 or 2, program addresses 0x2000–0x3FFF go external with `ext_pms` asserted. The external address is formed as {page==2, core address[12:0]}.
- R3: Data space register window. Data addresses 0x3FE0–0x3FFF assert `regwin_en`, with `regwin_idx` equal to address[4:0]. Data addresses 0x2000–0x3FDF go to internal RAM (`ram_dm_en`).
- R4: Data space overlay. Data addresses 0x0000–0x1FFF go to internal RAM while the data overlay is 0. With the data overlay at 1 or 2 they go external with `ext_dms` asserted. The external address is formed as {page==2, address[12:0]}.
- R5: Compatibility mode (strap 1). Program addresses 0x0000–0x1FFF go external with `ext_addr` equal to the core address. Program addresses 0x2000–0x3FFF go internal. A nonzero write to the program overlay is rejected; data overlay writes are unaffected.
- R6: A fetch and a program-space data access that both hit internal RAM are both enabled in the same cycle, with `core_ready` high.
- R7: An overlay write whose value is 3 or more leaves that register unchanged. The same applies to the rejected write of R5. Either kind of rejected write raises `ovl_err` in the next cycle only.
- R8: Both overlay registers reset to 0. An access in the same cycle as an overlay write is routed with the old value. The new value applies from the next cycle.
- R9: An external access begins in the cycle after the request. It holds `ext_addr`, one select strobe, and `ext_rd` or `ext_wr` for WAIT_STATES+1 cycles, and drives the write data on `ext_dout`. `core_ready` stays low from the request cycle until WAIT_STATES+2 cycles have passed.
- R10: When a fetch and a data access both need the bus, the data access runs first. The fetch runs next, after one idle cycle, and `core_ready` stays low for 2*WAIT_STATES+4 cycles.
- R11: External read data is captured at the end of the access. It is presented on `acc_rdata` (data port) or `fetch_rdata` (fetch port) in the cycle in which `core_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compat_mode | input | 1 | Layout strap: 0 normal, 1 compatibility |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 14 | Fetch word address |
| fetch_rdata | output | 24 | Fetch data returned from the external bus |
| acc_req | input | 1 | Data access request |
| acc_pm | input | 1 | Data access targets program space (1) or data space (0) |
| acc_wr | input | 1 | Data access is a write |
| acc_addr | input | 14 | Data access word address |
| acc_wdata | input | 24 | Write data |
| acc_rdata | output | 24 | Data returned from the external bus |
| ovl_we | input | 1 | Overlay register write strobe |
| ovl_sel | input | 1 | 0 program overlay, 1 data overlay |
| ovl_wdata | input | 4 | Overlay value to write |
| ovl_err | output | 1 | One-cycle flag for a rejected write |
| core_ready | output | 1 | Low while requested external accesses are pending |
| ram_fetch_en | output | 1 | Fetch enable to internal program RAM |
| ram_pmdata_en | output | 1 | Data enable to internal program RAM |
| ram_dm_en | output | 1 | Enable to internal data RAM |
| regwin_en | output | 1 | Register window access |
| regwin_idx | output | 5 | Register index in the window |
| ext_addr | output | 14 | External address |
| ext_pms | output | 1 | External program-space select |
| ext_dms | output | 1 | External data-space select |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_dout | output | 24 | External write data |
| ext_din | input | 24 | External read data |

## Verification
A table drives data-port accesses across every region edge: 0x1FFF/0x2000, 0x3FDF/0x3FE0 and 0x3FFF. Each address is tried under overlay values 0, 1 and 2. This separates internal, register window and external routing, and shows whether the page bit lands on bit 13. Directed cases then cover the following:
- illegal and compatibility-rejected writes, where a later access shows the old page still in force;
- a write in the same cycle as an access, which tells old-value routing from new-value routing;
- two simultaneous internal program reads;
- a fetch and a data access that both go external, where the strobe order and the ready-low length tell data-first service from fetch-first service.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ADDR_W    = 14;
  localparam int HALF_BIT  = ADDR_W - 1;
  localparam int REG_IDX_W = 5;
  localparam logic [ADDR_W-1:0] REGWIN_BASE = 14'h3FE0;

  typedef enum logic [1:0] {RT_INT = 2'd0, RT_REG = 2'd1, RT_EXT = 2'd2} route_e;

  typedef struct packed {
    route_e              rt;
    logic [ADDR_W-1:0]   ext_addr;
  } map_t;

  // Page number to external address: bit 13 carries page-1, low bits pass through.
  function automatic logic [ADDR_W-1:0] page_addr(input logic [1:0] page,
                                                   input logic [ADDR_W-1:0] a);
    return {page == 2'd2, a[HALF_BIT-1:0]};
  endfunction

  function automatic map_t map_addr(input logic is_pm, input logic compat,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [1:0] pmo, input logic [1:0] dmo);
    map_t m;
    m.rt = RT_INT;
    m.ext_addr = '0;
    if (is_pm) begin
      if (compat) begin
        if (!a[HALF_BIT]) begin
          m.rt = RT_EXT;
          m.ext_addr = page_addr(2'd1, a);
        end
      end else if (a[HALF_BIT] && pmo != 2'd0) begin
        m.rt = RT_EXT;
        m.ext_addr = page_addr(pmo, a);
      end
    end else begin
      if (a >= REGWIN_BASE) m.rt = RT_REG;
      else if (!a[HALF_BIT] && dmo != 2'd0) begin
        m.rt = RT_EXT;
        m.ext_addr = page_addr(dmo, a);
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ovl_regs.sv
module ovl_regs #(
  parameter int OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compat,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [OVL_W-1:0] wr_data,
  output logic [1:0]       pm_ovl,
  output logic [1:0]       dm_ovl,
  output logic             err
);
  localparam logic [OVL_W-1:0] MAX_PAGE = OVL_W'(2);

  logic in_range, compat_block, accept;
  always_comb begin
    in_range     = wr_data <= MAX_PAGE;
    compat_block = compat && !wr_sel && (wr_data != '0);
    accept       = wr_en && in_range && !compat_block;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_ovl <= 2'd0;
      dm_ovl <= 2'd0;
      err    <= 1'b0;
    end else begin
      err <= wr_en && !accept;
      if (accept && !wr_sel) pm_ovl <= wr_data[1:0];
      if (accept &&  wr_sel) dm_ovl <= wr_data[1:0];
    end
  end

  a_r7_pm_in_range: assert property (@(posedge clk) disable iff (!rst_n) pm_ovl != 2'd3);
  a_r7_dm_in_range: assert property (@(posedge clk) disable iff (!rst_n) dm_ovl != 2'd3);
  a_r7_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en));
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(pm_ovl) && $stable(dm_ovl)));
endmodule

// File: rtl/ovl_port_map.sv
module ovl_port_map
  import ovl_pkg::*;
(
  input  logic              req,
  input  logic              is_pm,
  input  logic              compat,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        pm_ovl,
  input  logic [1:0]        dm_ovl,
  output logic              hit_int,
  output logic              hit_reg,
  output logic              hit_ext,
  output logic [ADDR_W-1:0] ext_addr
);
  map_t m;
  always_comb begin
    m        = map_addr(is_pm, compat, addr, pm_ovl, dm_ovl);
    hit_int  = req && (m.rt == RT_INT);
    hit_reg  = req && (m.rt == RT_REG);
    hit_ext  = req && (m.rt == RT_EXT);
    ext_addr = m.ext_addr;
  end
endmodule

// File: rtl/ovl_ext_seq.sv
module ovl_ext_seq #(
  parameter int DATA_W      = 24,
  parameter int AW          = 14,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              need_d,
  input  logic              d_is_pm,
  input  logic              d_wr,
  input  logic [AW-1:0]     d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic              need_f,
  input  logic [AW-1:0]     f_addr,
  input  logic [DATA_W-1:0] ext_din,
  output logic              ready,
  output logic [DATA_W-1:0] d_rdata,
  output logic [DATA_W-1:0] f_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic              ext_pms,
  output logic              ext_dms,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [DATA_W-1:0] ext_dout
);
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  logic              busy, cur_data, cur_pm, cur_wr, done_d, done_f;
  logic [CNT_W-1:0]  cnt;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] dout_q;
  logic              pend_d, pend_f, start_d, start_f, finish;

  always_comb begin
    pend_d  = need_d && !done_d;
    pend_f  = need_f && !done_f;
    ready   = !pend_d && !pend_f;
    start_d = !busy && pend_d;
    start_f = !busy && !pend_d && pend_f;
    finish  = busy && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_data <= 1'b0; cur_pm <= 1'b0; cur_wr <= 1'b0;
      done_d <= 1'b0; done_f <= 1'b0; cnt <= '0;
      addr_q <= '0; dout_q <= '0; d_rdata <= '0; f_rdata <= '0;
    end else begin
      if (start_d || start_f) begin
        busy     <= 1'b1;
        cnt      <= CNT_W'(WAIT_STATES);
        cur_data <= start_d;
        cur_pm   <= start_d ? d_is_pm : 1'b1;
        cur_wr   <= start_d && d_wr;
        addr_q   <= start_d ? d_addr : f_addr;
        dout_q   <= (start_d && d_wr) ? d_wdata : '0;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (finish) begin
        if (cur_data) begin done_d <= 1'b1; d_rdata <= ext_din; end
        else          begin done_f <= 1'b1; f_rdata <= ext_din; end
      end
      if (ready) begin
        done_d <= 1'b0;
        done_f <= 1'b0;
      end
    end
  end

  always_comb begin
    ext_pms  = busy && cur_pm;
    ext_dms  = busy && !cur_pm;
    ext_rd   = busy && !cur_wr;
    ext_wr   = busy && cur_wr;
    ext_addr = busy ? addr_q : '0;
    ext_dout = (busy && cur_wr) ? dout_q : '0;
  end

  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_pms, ext_dms}));
  a_r9_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_rd, ext_wr}));
  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ext_addr));
  a_r9_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);
  a_r10_data_before_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_data) |-> (done_d || !need_d));
endmodule

// File: rtl/ovl_addr_ctrl.sv
module ovl_addr_ctrl
  import ovl_pkg::*;
#(
  parameter int PM_W        = 24,
  parameter int OVL_W       = 4,
  parameter int WAIT_STATES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 compat_mode,
  input  logic                 fetch_req,
  input  logic [ADDR_W-1:0]    fetch_addr,
  output logic [PM_W-1:0]      fetch_rdata,
  input  logic                 acc_req,
  input  logic                 acc_pm,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [PM_W-1:0]      acc_wdata,
  output logic [PM_W-1:0]      acc_rdata,
  input  logic                 ovl_we,
  input  logic                 ovl_sel,
  input  logic [OVL_W-1:0]     ovl_wdata,
  output logic                 ovl_err,
  output logic                 core_ready,
  output logic                 ram_fetch_en,
  output logic                 ram_pmdata_en,
  output logic                 ram_dm_en,
  output logic                 regwin_en,
  output logic [REG_IDX_W-1:0] regwin_idx,
  output logic [ADDR_W-1:0]    ext_addr,
  output logic                 ext_pms,
  output logic                 ext_dms,
  output logic                 ext_rd,
  output logic                 ext_wr,
  output logic [PM_W-1:0]      ext_dout,
  input  logic [PM_W-1:0]      ext_din
);
  logic [1:0]        pm_ovl, dm_ovl;
  logic              f_int, f_reg, f_ext, d_int, d_reg, d_ext;
  logic [ADDR_W-1:0] f_xaddr, d_xaddr;

  ovl_regs #(.OVL_W(OVL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .compat(compat_mode),
    .wr_en(ovl_we), .wr_sel(ovl_sel), .wr_data(ovl_wdata),
    .pm_ovl(pm_ovl), .dm_ovl(dm_ovl), .err(ovl_err));

  ovl_port_map fetch_map_i (
    .req(fetch_req), .is_pm(1'b1), .compat(compat_mode), .addr(fetch_addr),
    .pm_ovl(pm_ovl), .dm_ovl(dm_ovl),
    .hit_int(f_int), .hit_reg(f_reg), .hit_ext(f_ext), .ext_addr(f_xaddr));

  ovl_port_map acc_map_i (
    .req(acc_req), .is_pm(acc_pm), .compat(compat_mode), .addr(acc_addr),
    .pm_ovl(pm_ovl), .dm_ovl(dm_ovl),
    .hit_int(d_int), .hit_reg(d_reg), .hit_ext(d_ext), .ext_addr(d_xaddr));

  ovl_ext_seq #(.DATA_W(PM_W), .AW(ADDR_W), .WAIT_STATES(WAIT_STATES)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .need_d(d_ext), .d_is_pm(acc_pm), .d_wr(acc_wr), .d_addr(d_xaddr), .d_wdata(acc_wdata),
    .need_f(f_ext), .f_addr(f_xaddr), .ext_din(ext_din),
    .ready(core_ready), .d_rdata(acc_rdata), .f_rdata(fetch_rdata),
    .ext_addr(ext_addr), .ext_pms(ext_pms), .ext_dms(ext_dms),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_dout(ext_dout));

  always_comb begin
    ram_fetch_en  = f_int && core_ready;
    ram_pmdata_en = d_int && acc_pm && core_ready;
    ram_dm_en     = d_int && !acc_pm && core_ready;
    regwin_en     = d_reg && core_ready;
    regwin_idx    = acc_addr[REG_IDX_W-1:0];
  end

  a_r3_data_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_pmdata_en, ram_dm_en, regwin_en}));
  a_r3_fetch_never_regwin: assert property (@(posedge clk) disable iff (!rst_n)
    !f_reg);
  a_r5_compat_pm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    compat_mode |-> (pm_ovl == 2'd0));
  a_r9_strobe_stalls_core: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pms || ext_dms) |-> !core_ready);
endmodule

// File: tb/ovl_addr_ctrl_tb_top.sv
module ovl_addr_ctrl_tb_top;
  localparam int W = 2;
  localparam logic [9:0] DIN_TAG = 10'h15A;

  typedef struct packed {
    logic [1:0]  pmo;
    logic [1:0]  dmo;
    logic        pm;
    logic        wr;
    logic [13:0] addr;
    logic [1:0]  rt;   // 0 internal, 1 register window, 2 external
    logic [13:0] ea;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b1, 1'b0, 14'h0123, 2'd0, 14'h0000},
    '{2'd0, 2'd0, 1'b1, 1'b0, 14'h2ABC, 2'd0, 14'h0000},
    '{2'd1, 2'd0, 1'b1, 1'b0, 14'h2ABC, 2'd2, 14'h0ABC},
    '{2'd2, 2'd0, 1'b1, 1'b0, 14'h3FFF, 2'd2, 14'h3FFF},
    '{2'd2, 2'd0, 1'b1, 1'b0, 14'h1FFF, 2'd0, 14'h0000},
    '{2'd1, 2'd0, 1'b1, 1'b1, 14'h2000, 2'd2, 14'h0000},
    '{2'd0, 2'd0, 1'b0, 1'b0, 14'h3FE0, 2'd1, 14'h0000},
    '{2'd0, 2'd2, 1'b0, 1'b0, 14'h3FFF, 2'd1, 14'h0000},
    '{2'd0, 2'd1, 1'b0, 1'b0, 14'h3FDF, 2'd0, 14'h0000},
    '{2'd0, 2'd0, 1'b0, 1'b0, 14'h0040, 2'd0, 14'h0000},
    '{2'd0, 2'd1, 1'b0, 1'b1, 14'h1234, 2'd2, 14'h1234},
    '{2'd0, 2'd2, 1'b0, 1'b0, 14'h0000, 2'd2, 14'h2000},
    '{2'd0, 2'd2, 1'b0, 1'b0, 14'h1FFF, 2'd2, 14'h3FFF},
    '{2'd0, 2'd2, 1'b0, 1'b0, 14'h2000, 2'd0, 14'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, compat_mode = 1'b0;
  logic fetch_req = 1'b0, acc_req = 1'b0, acc_pm = 1'b0, acc_wr = 1'b0;
  logic [13:0] fetch_addr = '0, acc_addr = '0;
  logic [23:0] acc_wdata = '0, fetch_rdata, acc_rdata, ext_dout, ext_din;
  logic ovl_we = 1'b0, ovl_sel = 1'b0;
  logic [3:0] ovl_wdata = '0;
  logic ovl_err, core_ready, ram_fetch_en, ram_pmdata_en, ram_dm_en, regwin_en;
  logic [4:0] regwin_idx;
  logic [13:0] ext_addr;
  logic ext_pms, ext_dms, ext_rd, ext_wr;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  assign ext_din = {DIN_TAG, ext_addr};

  ovl_addr_ctrl #(.WAIT_STATES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
    .acc_req(acc_req), .acc_pm(acc_pm), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ovl_we(ovl_we), .ovl_sel(ovl_sel), .ovl_wdata(ovl_wdata), .ovl_err(ovl_err),
    .core_ready(core_ready), .ram_fetch_en(ram_fetch_en), .ram_pmdata_en(ram_pmdata_en),
    .ram_dm_en(ram_dm_en), .regwin_en(regwin_en), .regwin_idx(regwin_idx),
    .ext_addr(ext_addr), .ext_pms(ext_pms), .ext_dms(ext_dms), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_dout(ext_dout), .ext_din(ext_din));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset(input logic cm);
    @(negedge clk);
    rst_n = 1'b0; compat_mode = cm;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_ovl(input logic sel, input logic [3:0] val);
    @(negedge clk);
    ovl_we = 1'b1; ovl_sel = sel; ovl_wdata = val;
    @(negedge clk);
    ovl_we = 1'b0;
    #2;
  endtask

  // Called after the request cycle was checked; walks strobes, then the ready cycle.
  task automatic ext_walk(input string tag, input logic pm, input logic wr,
                          input logic [13:0] ea, input logic is_fetch);
    for (int k = 1; k <= W + 1; k++) begin
      @(negedge clk); #2;
      check({tag, " strobe"}, {ext_pms, ext_dms, ext_rd, ext_wr}, {pm, !pm, !wr, wr});
      check({tag, " ext_addr"}, ext_addr, ea);
      if (wr) check({tag, " ext_dout"}, ext_dout, acc_wdata);
      check({tag, " stall"}, core_ready, 1'b0);
    end
    @(negedge clk); #2;
    check({tag, " ready"}, core_ready, 1'b1);
    check({tag, " strobes off"}, {ext_pms, ext_dms}, 2'b00);
    if (!wr) check("R11 rdata", is_fetch ? fetch_rdata : acc_rdata, {DIN_TAG, ea});
    @(negedge clk);
    fetch_req = 1'b0; acc_req = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset(1'b0);
    #2;
    check("R8 reset ready", core_ready, 1'b1);
    check("R8 reset outputs", {ovl_err, ext_pms, ext_dms, ext_rd, ext_wr, ram_fetch_en}, 6'b0);
    // R8: reset value 0 means upper program half and lower data half are internal
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 14'h3000; acc_req = 1'b1; acc_pm = 1'b0; acc_addr = 14'h0100;
    #2;
    check("R8 reset pm ovl zero", ram_fetch_en, 1'b1);
    check("R8 reset dm ovl zero", ram_dm_en, 1'b1);
    @(negedge clk); fetch_req = 1'b0; acc_req = 1'b0;

    // Table of data-port routings
    for (int v = 0; v < NV; v++) begin
      string tag;
      wr_ovl(1'b0, {2'b00, VECS[v].pmo});
      wr_ovl(1'b1, {2'b00, VECS[v].dmo});
      if (VECS[v].pm) tag = (VECS[v].rt == 2'd2) ? "R2" : "R1";
      else tag = (VECS[v].addr[13] || VECS[v].rt == 2'd1) ? "R3" : "R4";
      @(negedge clk);
      acc_req = 1'b1; acc_pm = VECS[v].pm; acc_wr = VECS[v].wr;
      acc_addr = VECS[v].addr; acc_wdata = 24'hC0FFEE ^ {10'h0, VECS[v].addr};
      #2;
      if (VECS[v].rt == 2'd2) begin
        check({tag, " req cycle stall"}, {core_ready, ext_pms, ext_dms}, 3'b000);
        ext_walk(tag, VECS[v].pm, VECS[v].wr, VECS[v].ea, 1'b0);
      end else begin
        check({tag, " ready"}, core_ready, 1'b1);
        check({tag, " target"}, {ram_pmdata_en, ram_dm_en, regwin_en},
              {VECS[v].rt == 2'd0 && VECS[v].pm, VECS[v].rt == 2'd0 && !VECS[v].pm,
               VECS[v].rt == 2'd1});
        if (VECS[v].rt == 2'd1) check("R3 regwin_idx", regwin_idx, VECS[v].addr[4:0]);
        @(negedge clk); acc_req = 1'b0;
      end
    end

    // R7: illegal value keeps page 2, error for exactly one cycle
    wr_ovl(1'b1, 4'd0);
    wr_ovl(1'b0, 4'd2);
    check("R7 legal write no err", ovl_err, 1'b0);
    wr_ovl(1'b0, 4'd3);
    check("R7 err raised", ovl_err, 1'b1);
    @(negedge clk); #2;
    check("R7 err one cycle", ovl_err, 1'b0);
    wr_ovl(1'b1, 4'hF);
    check("R7 err raised data", ovl_err, 1'b1);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 14'h2001;
    #2;
    check("R7 page kept stall", core_ready, 1'b0);
    ext_walk("R7 page kept", 1'b1, 1'b0, 14'h2001, 1'b1);
    @(negedge clk);
    acc_req = 1'b1; acc_pm = 1'b0; acc_wr = 1'b0; acc_addr = 14'h0005;
    #2;
    check("R7 dm kept 0", ram_dm_en, 1'b1);
    @(negedge clk); acc_req = 1'b0;

    // R8: same-cycle write uses the old value
    wr_ovl(1'b0, 4'd0);
    @(negedge clk);
    ovl_we = 1'b1; ovl_sel = 1'b0; ovl_wdata = 4'd1;
    fetch_req = 1'b1; fetch_addr = 14'h2100;
    #2;
    check("R8 old value used", {ram_fetch_en, core_ready}, 2'b11);
    @(negedge clk);
    ovl_we = 1'b0;
    #2;
    check("R8 new value next cycle", {ram_fetch_en, core_ready}, 2'b00);
    ext_walk("R8 new page", 1'b1, 1'b0, 14'h0100, 1'b1);

    // R6: two internal program accesses in one cycle
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 14'h0100;
    acc_req = 1'b1; acc_pm = 1'b1; acc_wr = 1'b0; acc_addr = 14'h0200;
    #2;
    check("R6 dual internal", {ram_fetch_en, ram_pmdata_en, core_ready}, 3'b111);
    @(negedge clk); fetch_req = 1'b0; acc_req = 1'b0;

    // R10: both external, data first
    wr_ovl(1'b1, 4'd1);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 14'h2010;
    acc_req = 1'b1; acc_pm = 1'b0; acc_addr = 14'h0020;
    for (int k = 0; k <= 2 * W + 4; k++) begin
      #2;
      check("R10 data strobe", ext_dms, (k >= 1 && k <= W + 1));
      check("R10 fetch strobe", ext_pms, (k >= W + 3 && k <= 2 * W + 3));
      if (k >= 1 && k <= W + 1) check("R10 data addr", ext_addr, 14'h0020);
      if (k >= W + 3 && k <= 2 * W + 3) check("R10 fetch addr", ext_addr, 14'h0010);
      check("R10 ready", core_ready, (k == 2 * W + 4));
      if (k < 2 * W + 4) @(negedge clk);
    end
    check("R11 data rdata", acc_rdata, {DIN_TAG, 14'h0020});
    check("R11 fetch rdata", fetch_rdata, {DIN_TAG, 14'h0010});
    @(negedge clk); fetch_req = 1'b0; acc_req = 1'b0;

    // R5: compatibility layout
    do_reset(1'b1);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 14'h0155;
    #2;
    check("R5 lower external stall", core_ready, 1'b0);
    ext_walk("R5 lower external", 1'b1, 1'b0, 14'h0155, 1'b1);
    wr_ovl(1'b0, 4'd1);
    check("R5 pm write rejected", ovl_err, 1'b1);
    wr_ovl(1'b1, 4'd2);
    check("R5 dm write accepted", ovl_err, 1'b0);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 14'h2155;
    #2;
    check("R5 upper internal", {ram_fetch_en, core_ready}, 2'b11);
    @(negedge clk); fetch_req = 1'b0;
    acc_req = 1'b1; acc_pm = 1'b0; acc_wr = 1'b0; acc_addr = 14'h0007;
    #2;
    check("R5 dm overlay active", core_ready, 1'b0);
    ext_walk("R5 dm overlay", 1'b0, 1'b0, 14'h2007, 1'b0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule